// File: doc/BRIEF.md
# Multi-Line Serial Flash Read Front End

This block is the device-side serial port of a small serial flash memory. A host selects the device with an active-low select, clocks in a one-byte command on line 0 and, depending on the command, a 24-bit address. Data then comes back from a small internal byte array. The plain read moves everything over one line in each direction. A dual read carries the address and data on lines 0 and 1. A quad read carries them on all four lines, but only after a quad-enable bit has been set in the second status register.

All pins are sampled with the block's own system clock, which must run several times faster than the serial clock. Serial clock edges are found by comparing two registered copies of the serial clock. Because only edges are used, the host may idle the serial clock either low (mode 0) or high (mode 3). The first falling edge seen in mode 3 lands before any command bit, so it has no effect.

Raising the select ends any command at once. It turns all output enables off and returns the decoder to waiting for a command byte.

Top module: `flashFront`

## Requirements
- R1: Command, address and status-write bits are taken on rising serial clock edges, with the serial clock idling either low or high while select changes. Both idle levels produce the same results.
- R2: Command 0x03 takes a 24-bit address on line 0, most significant bit first. Data then leaves on line 1 only, one bit after each falling edge, most significant bit first. During the data phase the output enables are 4'b0010.
- R3: Command 0xBB takes 32 bits over 16 clocks, two per clock with line 1 carrying the more significant bit. These are the 24-bit address followed by an 8-bit mode byte that is discarded. Data then leaves two bits per falling edge, line 1 carrying the higher bit. The output enables are 4'b0011.
- R4: With quad-enable set, command 0xEB takes address plus mode byte over 8 clocks, four bits per clock with line 3 carrying the most significant bit. Four dummy clocks follow. Data then leaves four bits per falling edge with output enables 4'b1111.
- R5: With quad-enable clear, command 0xEB is ignored: the output enables stay 0 until select rises.
- R6: Command 0x35 returns the second status byte on line 1 after each falling edge, repeating while clocks continue. In that byte, bit 1 is quad-enable and every other bit reads 0.
- R7: Command 0x31 followed by eight bits on line 0 sets quad-enable to bit 1 of that byte. The write takes effect only on the eighth bit, so a command cut short leaves quad-enable unchanged.
- R8: The read address steps by one after each complete byte and wraps from the last array byte (index MEM_BYTES-1) to byte 0.
- R9: Select high forces all output enables to 0 within two system clocks. The next select-low period starts with a fresh command byte.
- R10: Any other command byte produces no output; the enables stay 0 until select rises.
- R11: After reset, quad-enable is 0 and the output enables are 0. Array byte i holds (i*37 + 0x5A) mod 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Active-low device select |
| sclk | input | 1 | Serial clock from the host |
| ioIn | input | 4 | Input values of the four data lines |
| ioOut | output | 4 | Values driven onto the four data lines |
| ioOe | output | 4 | Per-line output enable |

## Verification
A wrong phase counter shows up one serial clock later at the ports: data bits shift by one or more positions, or the output enables turn on a clock early, late or on the wrong lines. A wrong lane-mode or source selection shows up on the very first falling edge of the data phase, as an enable pattern other than the one the command calls for. A quad-enable bit that changes without a completed status write shows up on the next quad command, which is then either served when it should be ignored or ignored when it should be served. A stuck decoder shows up on the first command after select rises.

// File: rtl/flashFrontPkg.sv
package flashFrontPkg;

  typedef enum logic [1:0] {
    LANE_X1,
    LANE_X2,
    LANE_X4
  } laneMode_t;

  typedef enum logic [2:0] {
    ST_OPC,
    ST_ADDR,
    ST_DUMMY,
    ST_WRSR,
    ST_DATA,
    ST_IDLE
  } phase_t;

  // control -> datapath strobes
  typedef struct packed {
    logic      clear;
    logic      shiftIn;
    logic      loadAddr;
    logic      writeStat;
    logic      drive;
    logic      srcStat;
    laneMode_t mode;
  } frontStrobes_t;

  localparam logic [7:0] CMD_READ  = 8'h03;
  localparam logic [7:0] CMD_DUAL  = 8'hBB;
  localparam logic [7:0] CMD_QUAD  = 8'hEB;
  localparam logic [7:0] CMD_RDST2 = 8'h35;
  localparam logic [7:0] CMD_WRST2 = 8'h31;
  localparam int         QE_BIT    = 1;

endpackage

// File: rtl/flashFrontCtrl.sv
module flashFrontCtrl
  import flashFrontPkg::*;
#(
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_CLKS = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csQ,
  input  logic          sclkRise,
  input  logic          sclkFall,
  input  logic          io0,
  input  logic          qe,
  output frontStrobes_t strb
);

  localparam int CNT_W = $clog2(ADDR_BITS + 8);
  localparam logic [CNT_W-1:0] LAST_X1    = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] LAST_X2    = CNT_W'((ADDR_BITS + 8) / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_X4    = CNT_W'((ADDR_BITS + 8) / 4 - 1);
  localparam logic [CNT_W-1:0] LAST_DUMMY = CNT_W'(DUMMY_CLKS - 1);
  localparam logic [CNT_W-1:0] LAST_BIT   = CNT_W'(7);

  phase_t           phase;
  logic [CNT_W-1:0] cnt;
  logic [6:0]       opcHist;
  laneMode_t        mode;
  logic             srcStat;
  logic [7:0]       opcode;
  logic [CNT_W-1:0] addrLast;

  always_comb begin
    opcode = {opcHist, io0};
    case (mode)
      LANE_X2: addrLast = LAST_X2;
      LANE_X4: addrLast = LAST_X4;
      default: addrLast = LAST_X1;
    endcase
    strb           = '0;
    strb.clear     = csQ;
    strb.mode      = mode;
    strb.srcStat   = srcStat;
    strb.shiftIn   = sclkRise && (phase == ST_ADDR || phase == ST_WRSR);
    strb.loadAddr  = sclkRise && phase == ST_ADDR && cnt == addrLast;
    strb.writeStat = sclkRise && phase == ST_WRSR && cnt == LAST_BIT;
    strb.drive     = sclkFall && phase == ST_DATA;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= ST_OPC;
      cnt     <= '0;
      opcHist <= '0;
      mode    <= LANE_X1;
      srcStat <= 1'b0;
    end else if (csQ) begin
      phase   <= ST_OPC;
      cnt     <= '0;
      opcHist <= '0;
      mode    <= LANE_X1;
      srcStat <= 1'b0;
    end else if (sclkRise) begin
      case (phase)
        ST_OPC: begin
          opcHist <= opcode[6:0];
          cnt     <= cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            cnt <= '0;
            case (opcode)
              CMD_READ: begin
                mode  <= LANE_X1;
                phase <= ST_ADDR;
              end
              CMD_DUAL: begin
                mode  <= LANE_X2;
                phase <= ST_ADDR;
              end
              CMD_QUAD: begin
                if (qe) begin
                  mode  <= LANE_X4;
                  phase <= ST_ADDR;
                end else begin
                  phase <= ST_IDLE;
                end
              end
              CMD_RDST2: begin
                mode    <= LANE_X1;
                srcStat <= 1'b1;
                phase   <= ST_DATA;
              end
              CMD_WRST2: begin
                mode  <= LANE_X1;
                phase <= ST_WRSR;
              end
              default: phase <= ST_IDLE;
            endcase
          end
        end
        ST_ADDR: begin
          cnt <= cnt + 1'b1;
          if (cnt == addrLast) begin
            cnt   <= '0;
            phase <= (mode == LANE_X4) ? ST_DUMMY : ST_DATA;
          end
        end
        ST_DUMMY: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_DUMMY) begin
            cnt   <= '0;
            phase <= ST_DATA;
          end
        end
        ST_WRSR: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_BIT) begin
            cnt   <= '0;
            phase <= ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/flashFrontData.sv
module flashFrontData
  import flashFrontPkg::*;
#(
  parameter int MEM_BYTES = 64,
  parameter int ADDR_BITS = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  frontStrobes_t strb,
  input  logic [3:0]    ioQ,
  output logic [3:0]    ioOut,
  output logic [3:0]    ioOe,
  output logic          qe
);

  localparam int MEM_AW = $clog2(MEM_BYTES);
  localparam int SH_W   = ADDR_BITS + 8;

  logic [7:0]           mem [MEM_BYTES];
  logic [SH_W-2:0]      sh;
  logic [SH_W-1:0]      shNext;
  logic [ADDR_BITS-1:0] rdAddr;
  logic [2:0]           bitPos;
  logic [7:0]           outSh;
  logic [7:0]           statByte;
  logic [7:0]           srcByte;
  logic [7:0]           byteNow;
  logic [2:0]           laneW;
  logic [3:0]           posSum;
  logic [3:0]           nextOut;
  logic [3:0]           nextOe;

  always_comb begin
    case (strb.mode)
      LANE_X2: begin
        shNext  = {sh[SH_W-3:0], ioQ[1], ioQ[0]};
        laneW   = 3'd2;
      end
      LANE_X4: begin
        shNext  = {sh[SH_W-5:0], ioQ};
        laneW   = 3'd4;
      end
      default: begin
        shNext  = {sh, ioQ[0]};
        laneW   = 3'd1;
      end
    endcase
    statByte         = '0;
    statByte[QE_BIT] = qe;
    srcByte  = strb.srcStat ? statByte : mem[rdAddr[MEM_AW-1:0]];
    byteNow  = (bitPos == 3'd0) ? srcByte : outSh;
    posSum   = {1'b0, bitPos} + {1'b0, laneW};
    case (strb.mode)
      LANE_X2: begin
        nextOut = {2'b00, byteNow[7:6]};
        nextOe  = 4'b0011;
      end
      LANE_X4: begin
        nextOut = byteNow[7:4];
        nextOe  = 4'b1111;
      end
      default: begin
        nextOut = {2'b00, byteNow[7], 1'b0};
        nextOe  = 4'b0010;
      end
    endcase
  end

  // array contents come from a reset pattern
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'(i * 37 + 90);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh <= '0;
    end else if (strb.shiftIn) begin
      sh <= shNext[SH_W-2:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qe <= 1'b0;
    end else if (strb.writeStat) begin
      qe <= shNext[QE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAddr <= '0;
      bitPos <= '0;
      outSh  <= '0;
      ioOut  <= '0;
      ioOe   <= '0;
    end else if (strb.clear) begin
      bitPos <= '0;
      ioOe   <= '0;
    end else begin
      if (strb.loadAddr) begin
        rdAddr <= (strb.mode == LANE_X1) ? shNext[ADDR_BITS-1:0] : shNext[SH_W-1:8];
        bitPos <= '0;
      end
      if (strb.drive) begin
        ioOut  <= nextOut;
        ioOe   <= nextOe;
        outSh  <= byteNow << laneW;
        bitPos <= posSum[2:0];
        if (posSum[3]) rdAddr <= rdAddr + 1'b1;
      end
    end
  end

endmodule

// File: rtl/flashFront.sv
module flashFront
  import flashFrontPkg::*;
#(
  parameter int MEM_BYTES  = 64,
  parameter int ADDR_BITS  = 24,
  parameter int DUMMY_CLKS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic [3:0] ioIn,
  output logic [3:0] ioOut,
  output logic [3:0] ioOe
);

  logic          csQ;
  logic          sclkQ;
  logic          sclkQQ;
  logic [3:0]    ioQ;
  logic          sclkRise;
  logic          sclkFall;
  logic          qe;
  frontStrobes_t strb;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csQ    <= 1'b1;
      sclkQ  <= 1'b0;
      sclkQQ <= 1'b0;
      ioQ    <= '0;
    end else begin
      csQ    <= csN;
      sclkQ  <= sclk;
      sclkQQ <= sclkQ;
      ioQ    <= ioIn;
    end
  end

  assign sclkRise = sclkQ & ~sclkQQ & ~csQ;
  assign sclkFall = ~sclkQ & sclkQQ & ~csQ;

  flashFrontCtrl #(
    .ADDR_BITS (ADDR_BITS),
    .DUMMY_CLKS(DUMMY_CLKS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .csQ     (csQ),
    .sclkRise(sclkRise),
    .sclkFall(sclkFall),
    .io0     (ioQ[0]),
    .qe      (qe),
    .strb    (strb)
  );

  flashFrontData #(
    .MEM_BYTES(MEM_BYTES),
    .ADDR_BITS(ADDR_BITS)
  ) data_i (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb),
    .ioQ  (ioQ),
    .ioOut(ioOut),
    .ioOe (ioOe),
    .qe   (qe)
  );

endmodule

// File: rtl/flashFrontChk.sv
module flashFrontChk (
  input logic       clk,
  input logic       rstN,
  input logic       csN,
  input logic [3:0] ioOe,
  input logic [3:0] ioOut,
  input logic       qe,
  input logic       writeStat,
  input logic       drive
);

  AST_OE_OFF_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |=> (ioOe == 4'b0000)); // R9

  AST_OE_LEGAL_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'b0000 || ioOe == 4'b0010 || ioOe == 4'b0011 || ioOe == 4'b1111)); // R2

  AST_QUAD_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ioOe == 4'b1111) |-> qe); // R5

  AST_QE_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (qe != $past(qe)) |-> $past(writeStat)); // R7

  AST_OUT_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (ioOut != $past(ioOut)) |-> $past(drive)); // R2

endmodule

bind flashFront flashFrontChk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .csN      (csN),
  .ioOe     (ioOe),
  .ioOut    (ioOut),
  .qe       (qe),
  .writeStat(strb.writeStat),
  .drive    (strb.drive)
);

// File: tb/flashFront_tb_top.sv
`timescale 1ns / 1ps
module flashFront_tb_top;

  localparam int MEM = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sclk = 1'b0;
  logic [3:0] ioDrv = '0;
  logic [3:0] ioOut;
  logic [3:0] ioOe;

  int nChk = 0;
  int nFail = 0;
  int csHi = 0;

  always #10 clk = ~clk;

  flashFront dut_i (
    .clk  (clk),
    .rstN (rstN),
    .csN  (csN),
    .sclk (sclk),
    .ioIn (ioDrv),
    .ioOut(ioOut),
    .ioOe (ioOe)
  );

  function automatic logic [7:0] memFn(int a);
    return 8'(((a % MEM) * 37) + 90);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // every clock: enables must be off once select has been high a while (R9)
  always @(negedge clk) begin
    if (rstN) begin
      if (csN) csHi++;
      else csHi = 0;
      if (csHi >= 3) check("R9 deselected enables", {28'b0, ioOe}, 32'h0);
    end
  end

  task automatic startTxn(bit m3);
    sclk  = m3;
    ioDrv = '0;
    repeat (4) @(negedge clk);
    csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic endTxn(bit m3);
    if (!m3) begin
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    csN = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 enables off after select rise", {28'b0, ioOe}, 32'h0);
    repeat (2) @(negedge clk);
  endtask

  task automatic clkIn(logic [3:0] v);
    sclk  = 1'b0;
    ioDrv = v;
    repeat (4) @(negedge clk);
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic clkOut(output logic [3:0] o, output logic [3:0] e);
    sclk = 1'b0;
    repeat (4) @(negedge clk);
    o = ioOut;
    e = ioOe;
    sclk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendX1(logic [31:0] v, int nBits);
    for (int i = nBits - 1; i >= 0; i--) clkIn({3'b000, v[i]});
  endtask

  task automatic sendX2(logic [31:0] v);
    for (int k = 0; k < 16; k++) clkIn({2'b00, v[31-2*k], v[30-2*k]});
  endtask

  task automatic sendX4(logic [31:0] v);
    for (int k = 0; k < 8; k++) clkIn(v[31-4*k -: 4]);
  endtask

  task automatic readBytes(int lanes, int addr, int n, bit isStat, logic [7:0] statVal,
                           string req);
    logic [3:0] o, e, expOe;
    logic [7:0] got, exp;
    expOe = (lanes == 1) ? 4'b0010 : (lanes == 2) ? 4'b0011 : 4'b1111;
    for (int b = 0; b < n; b++) begin
      exp = isStat ? statVal : memFn(addr + b);
      got = '0;
      for (int c = 0; c < 8 / lanes; c++) begin
        clkOut(o, e);
        check({req, " enables"}, {28'b0, e}, {28'b0, expOe});
        if (lanes == 1) got = {got[6:0], o[1]};
        else if (lanes == 2) got = {got[5:0], o[1:0]};
        else got = {got[3:0], o};
      end
      check({req, " data byte"}, {24'b0, got}, {24'b0, exp});
    end
  endtask

  task automatic silentClocks(int n, string req);
    logic [3:0] o, e;
    for (int c = 0; c < n; c++) begin
      clkOut(o, e);
      check(req, {28'b0, e}, 32'h0);
    end
  endtask

  task automatic writeStatus(bit m3, logic [7:0] v);
    startTxn(m3);
    sendX1(32'(8'h31), 8);
    sendX1(32'(v), 8);
    endTxn(m3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check("R11 reset enables", {28'b0, ioOe}, 32'h0);
    check("R11 reset outputs", {28'b0, ioOut}, 32'h0);

    // R2 R1 R11: single read, mode 0
    startTxn(1'b0);
    sendX1(32'h03, 8);
    sendX1(32'h000005, 24);
    readBytes(1, 5, 3, 1'b0, 8'h0, "R2 single read mode0");
    endTxn(1'b0);

    // R1 R8: single read in mode 3 crossing the array end
    startTxn(1'b1);
    sendX1(32'h03, 8);
    sendX1(32'h00003E, 24);
    readBytes(1, 62, 4, 1'b0, 8'h0, "R8 R1 single read wrap mode3");
    endTxn(1'b1);

    // R3: dual read
    startTxn(1'b0);
    sendX1(32'hBB, 8);
    sendX2({24'h000010, 8'hA5});
    readBytes(2, 16, 3, 1'b0, 8'h0, "R3 dual read");
    endTxn(1'b0);

    // R6: status with quad-enable clear
    startTxn(1'b0);
    sendX1(32'h35, 8);
    readBytes(1, 0, 2, 1'b1, 8'h00, "R6 status qe=0");
    endTxn(1'b0);

    // R5: quad read ignored without quad-enable
    startTxn(1'b0);
    sendX1(32'hEB, 8);
    sendX4({24'h000020, 8'h00});
    silentClocks(12, "R5 quad ignored");
    endTxn(1'b0);

    // R7: cut-short status write leaves quad-enable clear
    startTxn(1'b0);
    sendX1(32'h31, 8);
    sendX1(32'hF, 4);
    endTxn(1'b0);
    startTxn(1'b1);
    sendX1(32'h35, 8);
    readBytes(1, 0, 1, 1'b1, 8'h00, "R7 partial write no effect");
    endTxn(1'b1);

    // R7 R6: full write sets quad-enable
    writeStatus(1'b0, 8'hFF);
    startTxn(1'b0);
    sendX1(32'h35, 8);
    readBytes(1, 0, 2, 1'b1, 8'h02, "R7 R6 status after write");
    endTxn(1'b0);

    // R4: quad read in both idle levels, with wrap
    startTxn(1'b0);
    sendX1(32'hEB, 8);
    sendX4({24'h000020, 8'h5A});
    silentClocks(4, "R4 dummy clocks no output");
    readBytes(4, 32, 3, 1'b0, 8'h0, "R4 quad read mode0");
    endTxn(1'b0);
    startTxn(1'b1);
    sendX1(32'hEB, 8);
    sendX4({24'h12343F, 8'h00});
    silentClocks(4, "R4 dummy clocks no output");
    readBytes(4, 63, 2, 1'b0, 8'h0, "R4 R8 quad read wrap mode3");
    endTxn(1'b1);

    // R9: abort in the middle of a read, then a fresh command
    begin
      logic [3:0] o, e;
      startTxn(1'b0);
      sendX1(32'h03, 8);
      sendX1(32'h000007, 24);
      for (int i = 0; i < 3; i++) clkOut(o, e);
      endTxn(1'b0);
    end
    startTxn(1'b0);
    sendX1(32'h03, 8);
    sendX1(32'h000008, 24);
    readBytes(1, 8, 1, 1'b0, 8'h0, "R9 read after abort");
    endTxn(1'b0);

    // R10: unknown command
    startTxn(1'b0);
    sendX1(32'h9F, 8);
    silentClocks(16, "R10 unknown command silent");
    endTxn(1'b0);

    // R5: clearing quad-enable blocks quad again
    writeStatus(1'b1, 8'h00);
    startTxn(1'b0);
    sendX1(32'hEB, 8);
    sendX4({24'h000000, 8'h00});
    silentClocks(8, "R5 quad blocked after clear");
    endTxn(1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule